// File: doc/BRIEF.md
# Channel Mode and Self-Test Controller

This block sits between the serial configuration latch of an eight-channel discrete-input receiver and its analog front ends. It turns the committed configuration word (eight per-channel mode bits plus one self-test bit in the top position) and the power-up state into four control vectors per channel: pull-up enable, pull-down enable, test-stimulus enable and test-stimulus value. It also carries a behavioural model of the per-channel comparator, so that the effect of a self-test pattern or of an input stuck in the hysteresis band shows up on a digital output.

The block also owns the power-up sequence. After reset, or after a filtered supply-low event, it waits a programmable number of supply-good cycles before it accepts any configuration commit. Until the first accepted commit every channel is high impedance: no pull-up, no pull-down and no stimulus. A raw supply-low flag that persists for a programmable number of consecutive cycles clears the stored configuration and the comparator state and restarts the sequence. Shorter dips are filtered out.

Top module: `chan_mode_ctrl`

## Requirements
- R1: While reset is applied, and on the first cycle after it, every control output, every comparator output and the write-accepted flag read 0.
- R2: A commit is ignored (no write-accepted pulse, outputs unchanged) until STARTUP_CYC clock edges have seen supply_ok high since reset or since a brownout. Edges with supply_ok low do not advance this count.
- R3: An accepted commit raises wr_accepted for exactly the one cycle after the edge that sampled it. The first accepted commit ends the high-impedance state.
- R4: In normal mode (cfg_word bit N_CH equal to 0), mode bit i equal to 1 sets pu_en[i] and clears pd_en[i]. Mode bit i equal to 0 sets pd_en[i] and clears pu_en[i]. No stimulus is enabled.
- R5: pu_en[i] and pd_en[i] are never 1 together, in any state.
- R6: In self-test (cfg_word bit N_CH equal to 1), all pull-ups and pull-downs are off, tst_en is all ones and tst_val[i] equals mode bit i.
- R7: Each comparator output updates one edge after its inputs change. Level code 2'b00 gives 0, code 2'b01 gives 1, and codes 2'b10 and 2'b11 (inside the hysteresis band) hold the previous value.
- R8: While tst_en[i] is 1, din_bit[i] takes tst_val[i] on the next edge, whatever the level code is.
- R9: A channel whose level code is inside the band when self-test is turned off keeps reporting the last self-test value.
- R10: LOW_FILT_CYC consecutive edges with supply_ok low clear the configuration and the comparator state. All channels return to high impedance and the startup delay of R2 restarts.
- R11: A run of fewer than LOW_FILT_CYC low edges changes no output and does not stop commits from being accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Raw supply-good flag, unfiltered |
| cfg_commit | input | 1 | Latch-commit strobe, sampled on each edge |
| cfg_word | input | N_CH+1 | Bits N_CH-1..0 are channel modes, bit N_CH is self-test enable |
| lvl_code | input | 2*N_CH | Per-channel input level code, two bits per channel |
| pu_en | output | N_CH | Pull-up enable per channel |
| pd_en | output | N_CH | Pull-down enable per channel |
| tst_en | output | N_CH | Test-stimulus enable per channel |
| tst_val | output | N_CH | Test-stimulus value per channel |
| din_bit | output | N_CH | Comparator model output per channel |
| wr_accepted | output | 1 | One-cycle pulse for each accepted commit |

## Verification
The bench holds a commit strobe high across the end of the startup window, with a supply dip in the middle of the window. This catches a design that accepts one edge early, one edge late, or keeps counting while the supply is low. It turns self-test off while every channel sits in the hysteresis band; a comparator that drops to a default value, or that follows the pull mode instead of holding, reports the wrong pattern. It drives supply-low runs of exactly one edge less than the filter length and of exactly the filter length. A filter that is off by one either wipes the configuration on a glitch or survives a real brownout. It also commits right after a brownout to confirm that the startup window has re-armed.

// File: rtl/chm_pkg.sv
package chm_pkg;

    typedef enum logic {
        SEQ_STARTUP = 1'b0,
        SEQ_READY   = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic pull_up;
        logic pull_dn;
        logic stim_en;
        logic stim_val;
    } chan_ctl_t;

    localparam logic [1:0] LVL_LOW  = 2'b00;
    localparam logic [1:0] LVL_HIGH = 2'b01;

    // Per-channel front-end control from the committed word.
    function automatic chan_ctl_t chan_decode(input logic valid,
                                              input logic self_test,
                                              input logic mode_bit);
        chan_ctl_t c;
        c = '0;
        if (valid) begin
            if (self_test) begin
                c.stim_en  = 1'b1;
                c.stim_val = mode_bit;
            end else begin
                c.pull_up = mode_bit;
                c.pull_dn = ~mode_bit;
            end
        end
        return c;
    endfunction

    // Comparator with hold inside the hysteresis band.
    function automatic logic cmp_next(input logic stim_en,
                                      input logic stim_val,
                                      input logic [1:0] lvl,
                                      input logic prev);
        logic r;
        if (stim_en) begin
            r = stim_val;
        end else begin
            case (lvl)
                LVL_LOW:  r = 1'b0;
                LVL_HIGH: r = 1'b1;
                default:  r = prev;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/chm_por_seq.sv
module chm_por_seq
    import chm_pkg::*;
#(
    parameter int STARTUP_CYC  = 50000,
    parameter int LOW_FILT_CYC = 2250
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    output logic accepting,
    output logic wipe
);
    localparam int SW = $clog2(STARTUP_CYC + 1);
    localparam int LW = $clog2(LOW_FILT_CYC + 1);

    seq_state_e    state;
    logic [SW-1:0] st_cnt;
    logic [LW-1:0] low_cnt;

    assign wipe      = !supply_ok && (low_cnt == LW'(LOW_FILT_CYC - 1));
    assign accepting = (state == SEQ_READY) && !wipe;

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            state   <= SEQ_STARTUP;
            st_cnt  <= '0;
            low_cnt <= '0;
        end else begin
            low_cnt <= supply_ok ? '0 : low_cnt + LW'(1);
            if (state == SEQ_STARTUP && supply_ok) begin
                if (st_cnt == SW'(STARTUP_CYC - 1)) begin
                    state  <= SEQ_READY;
                    st_cnt <= '0;
                end else begin
                    st_cnt <= st_cnt + SW'(1);
                end
            end
        end
    end

    assert_startup_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_STARTUP) |-> (st_cnt < SW'(STARTUP_CYC)));

    assert_startup_pause_R2: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_STARTUP && !supply_ok && !wipe) |=> $stable(st_cnt));

    assert_wipe_restart_R10: assert property (@(posedge clk) disable iff (rst)
        wipe |=> (state == SEQ_STARTUP && st_cnt == '0));

    assert_filter_bound_R11: assert property (@(posedge clk) disable iff (rst)
        low_cnt < LW'(LOW_FILT_CYC));

endmodule

// File: rtl/chm_cfg_store.sv
module chm_cfg_store
    import chm_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wipe,
    input  logic            accepting,
    input  logic            commit,
    input  logic [N_CH:0]   cfg_word,
    output logic [N_CH-1:0] pu_en,
    output logic [N_CH-1:0] pd_en,
    output logic [N_CH-1:0] tst_en,
    output logic [N_CH-1:0] tst_val,
    output logic            wr_accepted
);
    localparam int TEST_BIT = N_CH;

    logic [N_CH:0] latch_q;
    logic          cfg_valid;
    logic          acc_q;

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            latch_q   <= '0;
            cfg_valid <= 1'b0;
            acc_q     <= 1'b0;
        end else begin
            acc_q <= commit && accepting;
            if (commit && accepting) begin
                latch_q   <= cfg_word;
                cfg_valid <= 1'b1;
            end
        end
    end

    assign wr_accepted = acc_q;

    for (genvar i = 0; i < N_CH; i++) begin : g_chan
        chan_ctl_t ctl;
        assign ctl        = chan_decode(cfg_valid, latch_q[TEST_BIT], latch_q[i]);
        assign pu_en[i]   = ctl.pull_up;
        assign pd_en[i]   = ctl.pull_dn;
        assign tst_en[i]  = ctl.stim_en;
        assign tst_val[i] = ctl.stim_val;
    end

    assert_pull_excl_R5: assert property (@(posedge clk) disable iff (rst)
        (pu_en & pd_en) == '0);

    assert_test_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (|tst_en) |-> ((pu_en | pd_en) == '0));

    assert_accept_gate_R2: assert property (@(posedge clk) disable iff (rst)
        wr_accepted |-> $past(commit && accepting));

    assert_first_write_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_valid) |-> wr_accepted);

endmodule

// File: rtl/chm_cmp_bank.sv
module chm_cmp_bank
    import chm_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wipe,
    input  logic [N_CH-1:0]   tst_en,
    input  logic [N_CH-1:0]   tst_val,
    input  logic [2*N_CH-1:0] lvl_code,
    output logic [N_CH-1:0]   din_bit
);
    for (genvar i = 0; i < N_CH; i++) begin : g_cmp
        logic q;
        always_ff @(posedge clk) begin
            if (rst || wipe) q <= 1'b0;
            else             q <= cmp_next(tst_en[i], tst_val[i], lvl_code[2*i +: 2], q);
        end
        assign din_bit[i] = q;

        assert_stim_follow_R8: assert property (@(posedge clk) disable iff (rst)
            ($past(tst_en[i]) && !$past(wipe)) |-> (din_bit[i] == $past(tst_val[i])));

        assert_band_hold_R9: assert property (@(posedge clk) disable iff (rst)
            (!$past(tst_en[i]) && $past(lvl_code[2*i+1]) && !$past(wipe))
                |-> $stable(din_bit[i]));
    end

endmodule

// File: rtl/chan_mode_ctrl.sv
module chan_mode_ctrl
    import chm_pkg::*;
#(
    parameter int N_CH         = 8,
    parameter int STARTUP_CYC  = 50000,
    parameter int LOW_FILT_CYC = 2250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok,
    input  logic              cfg_commit,
    input  logic [N_CH:0]     cfg_word,
    input  logic [2*N_CH-1:0] lvl_code,
    output logic [N_CH-1:0]   pu_en,
    output logic [N_CH-1:0]   pd_en,
    output logic [N_CH-1:0]   tst_en,
    output logic [N_CH-1:0]   tst_val,
    output logic [N_CH-1:0]   din_bit,
    output logic              wr_accepted
);
    logic accepting;
    logic wipe;

    chm_por_seq #(
        .STARTUP_CYC (STARTUP_CYC),
        .LOW_FILT_CYC(LOW_FILT_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .supply_ok(supply_ok),
        .accepting(accepting),
        .wipe     (wipe)
    );

    chm_cfg_store #(.N_CH(N_CH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wipe       (wipe),
        .accepting  (accepting),
        .commit     (cfg_commit),
        .cfg_word   (cfg_word),
        .pu_en      (pu_en),
        .pd_en      (pd_en),
        .tst_en     (tst_en),
        .tst_val    (tst_val),
        .wr_accepted(wr_accepted)
    );

    chm_cmp_bank #(.N_CH(N_CH)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .wipe    (wipe),
        .tst_en  (tst_en),
        .tst_val (tst_val),
        .lvl_code(lvl_code),
        .din_bit (din_bit)
    );

    assert_wipe_clears_R10: assert property (@(posedge clk) disable iff (rst)
        wipe |=> (pu_en == '0 && pd_en == '0 && tst_en == '0 && din_bit == '0 && !wr_accepted));

endmodule

// File: tb/chan_mode_ctrl_tb.sv
module chan_mode_ctrl_tb_top;
    localparam int N    = 8;
    localparam int SCYC = 40;
    localparam int LCYC = 6;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           supply_ok = 1'b0;
    logic           cfg_commit = 1'b0;
    logic [N:0]     cfg_word = '0;
    logic [2*N-1:0] lvl_code = '0;
    logic [N-1:0]   pu_en, pd_en, tst_en, tst_val, din_bit;
    logic           wr_accepted;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    chan_mode_ctrl #(.N_CH(N), .STARTUP_CYC(SCYC), .LOW_FILT_CYC(LCYC)) dut_i (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .cfg_commit(cfg_commit),
        .cfg_word(cfg_word), .lvl_code(lvl_code), .pu_en(pu_en), .pd_en(pd_en),
        .tst_en(tst_en), .tst_val(tst_val), .din_bit(din_bit), .wr_accepted(wr_accepted)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, compared every clock
    logic [N:0]   m_word;
    bit           m_valid, m_ready, m_acc;
    int           m_good, m_low;
    logic [N-1:0] m_din;

    always @(posedge clk) begin
        if (rst) begin
            m_word = '0; m_valid = 0; m_ready = 0; m_acc = 0;
            m_good = 0; m_low = 0; m_din = '0;
        end else if (!supply_ok && (m_low + 1 == LCYC)) begin
            m_word = '0; m_valid = 0; m_ready = 0; m_acc = 0;
            m_good = 0; m_low = 0; m_din = '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (m_valid && m_word[N])            m_din[i] = m_word[i];
                else if (lvl_code[2*i +: 2] == 2'd0) m_din[i] = 1'b0;
                else if (lvl_code[2*i +: 2] == 2'd1) m_din[i] = 1'b1;
            end
            m_acc = cfg_commit && m_ready;
            if (m_acc) begin
                m_word  = cfg_word;
                m_valid = 1;
            end
            if (!m_ready && supply_ok) begin
                m_good++;
                if (m_good == SCYC) m_ready = 1;
            end
            m_low = supply_ok ? 0 : m_low + 1;
        end
        #1;
        begin
            logic [N-1:0] e_pu, e_pd, e_te, e_tv;
            bit nrm, tst;
            nrm  = m_valid && !m_word[N];
            tst  = m_valid && m_word[N];
            e_pu = nrm ? m_word[N-1:0] : '0;
            e_pd = nrm ? ~m_word[N-1:0] : '0;
            e_te = tst ? '1 : '0;
            e_tv = tst ? m_word[N-1:0] : '0;
            chk("R4 clk pull-up", 32'(pu_en), 32'(e_pu));
            chk("R4 clk pull-down", 32'(pd_en), 32'(e_pd));
            chk("R6 clk stimulus", 32'({tst_en, tst_val}), 32'({e_te, e_tv}));
            chk("R7 clk comparator", 32'(din_bit), 32'(m_din));
            chk("R3 clk wr_accepted", 32'(wr_accepted), 32'(m_acc));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic commit_pulse(input logic [N:0] w);
        cfg_word = w;
        cfg_commit = 1'b1;
        tick(1);
        cfg_commit = 1'b0;
    endtask

    function automatic logic [2*N-1:0] all_lvl(input logic [1:0] c);
        logic [2*N-1:0] v;
        for (int i = 0; i < N; i++) v[2*i +: 2] = c;
        return v;
    endfunction

    initial begin
        tick(4);
        chk("R1 reset outputs", 32'({pu_en, pd_en, tst_en, tst_val}), 32'h0);
        chk("R1 reset din/ack", 32'({din_bit, wr_accepted}), 32'h0);
        rst = 1'b0;
        supply_ok = 1'b1;
        tick(1);
        chk("R1 after reset", 32'({pu_en, pd_en, din_bit, wr_accepted}), 32'h0);
        tick(9);
        commit_pulse(9'h0FF);
        chk("R2 early commit ignored", 32'({wr_accepted, pu_en, pd_en}), 32'h0);
        supply_ok = 1'b0;
        tick(3);
        supply_ok = 1'b1;
        begin
            int k;
            k = 0;
            cfg_word = 9'h0A5;
            cfg_commit = 1'b1;
            while (!wr_accepted && k < 100) begin
                tick(1);
                k++;
            end
            cfg_commit = 1'b0;
            chk("R2 startup edges until accept", 32'(k), 32'd30);
        end
        chk("R3 first write pull-up", 32'(pu_en), 32'hA5);
        chk("R4 first write pull-down", 32'(pd_en), 32'h5A);
        tick(1);
        chk("R3 ack one cycle", 32'(wr_accepted), 32'h0);

        commit_pulse(9'h0C3);
        chk("R4 normal pattern", 32'({pu_en, pd_en}), 32'hC33C);
        chk("R5 no pull overlap", 32'(pu_en & pd_en), 32'h0);
        chk("R6 no stimulus normal", 32'(tst_en), 32'h0);

        for (int i = 0; i < N; i++) lvl_code[2*i +: 2] = (i % 2 == 0) ? 2'b01 : 2'b00;
        tick(2);
        chk("R7 level decode", 32'(din_bit), 32'h55);
        lvl_code = all_lvl(2'b10);
        tick(2);
        chk("R7 band hold", 32'(din_bit), 32'h55);

        commit_pulse(9'h13C);
        chk("R6 test pulls off", 32'({pu_en, pd_en}), 32'h0);
        chk("R6 test stimulus", 32'({tst_en, tst_val}), 32'hFF3C);
        tick(1);
        chk("R8 stimulus to comparator", 32'(din_bit), 32'h3C);

        lvl_code = all_lvl(2'b11);
        commit_pulse(9'h000);
        chk("R4 all pull-down", 32'({pu_en, pd_en}), 32'h00FF);
        tick(2);
        chk("R9 stuck keeps test value", 32'(din_bit), 32'h3C);
        lvl_code = all_lvl(2'b01);
        tick(2);
        chk("R7 all high", 32'(din_bit), 32'hFF);

        supply_ok = 1'b0;
        tick(LCYC - 1);
        supply_ok = 1'b1;
        tick(1);
        chk("R11 glitch keeps config", 32'({pu_en, pd_en, din_bit}), 32'h00FFFF);
        commit_pulse(9'h0F0);
        chk("R11 still accepting", 32'(wr_accepted), 32'h1);

        supply_ok = 1'b0;
        tick(LCYC);
        chk("R10 brownout clears", 32'({pu_en, pd_en, tst_en, din_bit}), 32'h0);
        supply_ok = 1'b1;
        commit_pulse(9'h0FF);
        chk("R10 commit blocked after brownout", 32'({wr_accepted, pu_en}), 32'h0);
        tick(SCYC + 2);
        commit_pulse(9'h0AA);
        chk("R10 accepted after new startup", 32'({wr_accepted, pu_en}), 32'h1AA);
        tick(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule